// File: doc/BRIEF.md
# Strobed Dual-Register Synthesiser Program Port

This block is the programming front end of a frequency synthesiser. A host presents a 16-bit word, one address bit and a level-sensitive strobe. A load places the word in one of two registers. The divider register sets the dual-modulus swallow count, the main count and the charge-pump gain code. The reference register sets the reference divide count, the phase-detector operating state and the detector sense. The block decodes both registers into fields for the counter and detector blocks next to it.

The host inputs pass through a synchroniser before the block evaluates them. While the synchronised strobe is high, the block does three things:
- It holds the counters in reset.
- It disables the charge pump.
- It tracks the bus and the address into a staging register.

When the strobe falls, the block commits the last value it tracked to the register the address selected. In the same cycle it releases the counters. While the strobe is low, the block ignores the bus. After the reference register is set once, a frequency change takes only one divider-register load.

Top module: `pgm_strobe_if`

## Requirements
- R1: After reset, every decoded field is zero, `ref_valid_o` is 0, and `cnt_rst_o` and `cp_disable_o` are 0.
- R2: A load with address 1 writes the divider register. A load with address 0 writes the reference register.
- R3: While the strobe is low, changes on `bus_i` and `addr_i` leave every output unchanged.
- R4: `cnt_rst_o` and `cp_disable_o` go high SYNC_STAGES+1 clock cycles after the strobe rises. They go low SYNC_STAGES+1 cycles after it falls, in the same cycle the new register value first appears.
- R5: The word and address kept are the last ones presented while the strobe was high. A bus change made in the same cycle as the falling strobe is not kept.
- R6: In the reference word, bits 9..0 are the reference count, bits 11..10 are the detector state and bit 12 is the sense. Bits 15..13 have no effect.
- R7: In the divider word, bits 2..0 are the swallow count, bits 13..3 are the main count and bits 15..14 are the gain code.
- R8: `cp_gain_half_o` gives the pump current multiple in half units. Gain code 00 gives 2, 01 gives 3, 10 gives 5 and 11 gives 8.
- R9: Detector state 00 gives detector on with monitor outputs off. State 01 gives detector on with monitor outputs on. State 10 gives lock handoff with monitor outputs on. State 11 gives detector off with monitor outputs on. `pd_enable_o` is high only for 00 and 01, `pd_lock_handoff_o` only for 10, and `pd_mon_en_o` for every state except 00.
- R10: `pd_swap_o` equals the stored sense bit (reference word bit 12).
- R11: `ref_valid_o` rises at the first reference commit and then stays high until reset.
- R12: A divider load leaves all reference fields unchanged, and a reference load leaves all divider fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strb_i | input | 1 | Host load strobe, level sensitive |
| addr_i | input | 1 | Register select: 1 selects divider, 0 selects reference |
| bus_i | input | 16 | Host program word |
| cnt_rst_o | output | 1 | Counter reset while a load is in progress |
| cp_disable_o | output | 1 | Charge-pump disable while a load is in progress |
| a_cnt_o | output | 3 | Swallow (dual-modulus) count |
| m_cnt_o | output | 11 | Main divider count |
| cp_gain_o | output | 2 | Raw gain code |
| cp_gain_half_o | output | 4 | Pump current multiple in half units |
| ref_cnt_o | output | 10 | Reference divide count |
| pd_state_o | output | 2 | Raw detector state code |
| pd_enable_o | output | 1 | Internal detector enabled |
| pd_mon_en_o | output | 1 | Monitor outputs enabled |
| pd_lock_handoff_o | output | 1 | Detector hands off to an external detector on lock |
| pd_swap_o | output | 1 | Detector inputs transposed |
| ref_valid_o | output | 1 | Reference register has been loaded at least once |

## Verification
The bench builds the block with SYNC_STAGES = 2. This gives an edge-to-output latency of three cycles. Each R4 window edge can therefore be probed one cycle early and exactly on time.

The word width stays at 16 bits, so random words reach every gain code and every detector state. They also set the spare reference bits. Strobes as short as one cycle and bus changes in the same cycle as the falling strobe are both reachable at this synchroniser depth.

// File: rtl/pgm_if_pkg.sv
package pgm_if_pkg;

    localparam int WORD_W     = 16;
    localparam int A_W        = 3;
    localparam int M_W        = 11;
    localparam int GAIN_W     = 2;
    localparam int REFC_W     = 10;
    localparam int PDS_W      = 2;
    localparam int HALF_W     = 4;

    localparam int A_LSB      = 0;
    localparam int M_LSB      = A_LSB + A_W;
    localparam int GAIN_LSB   = M_LSB + M_W;
    localparam int REFC_LSB   = 0;
    localparam int PDS_LSB    = REFC_LSB + REFC_W;
    localparam int SENSE_BIT  = PDS_LSB + PDS_W;
    localparam int REF_USED_W = SENSE_BIT + 1;

    // divider word, msb first
    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [M_W-1:0]    m;
        logic [A_W-1:0]    a;
    } rf_word_t;

    // used part of the reference word, msb first
    typedef struct packed {
        logic              sense;
        logic [PDS_W-1:0]  pds;
        logic [REFC_W-1:0] refc;
    } ref_word_t;

    typedef enum logic [PDS_W-1:0] {
        PDS_RUN_QUIET  = 2'b00,
        PDS_RUN_MON    = 2'b01,
        PDS_HANDOFF    = 2'b10,
        PDS_OFF_MON    = 2'b11
    } pd_state_e;

    typedef struct packed {
        logic              strb_prev;
        logic [WORD_W-1:0] stage_word;
        logic              stage_addr;
        rf_word_t          rf;
        ref_word_t         refw;
        logic              ref_valid;
    } seq_state_t;

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
    parameter int WIDTH  = 18,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = async_i;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pgm_load_seq.sv
module pgm_load_seq
    import pgm_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_s,
    input  logic              addr_s,
    input  logic [WORD_W-1:0] bus_s,
    output logic              hold_o,
    output rf_word_t          rf_o,
    output ref_word_t         ref_o,
    output logic              ref_valid_o
);

    seq_state_t st_q, st_d;
    logic       release_d;

    always_comb begin
        st_d           = st_q;
        st_d.strb_prev = strb_s;
        release_d      = st_q.strb_prev && !strb_s;

        // track while strobe is high
        if (strb_s) begin
            st_d.stage_word = bus_s;
            st_d.stage_addr = addr_s;
        end

        // commit on the falling edge
        if (release_d) begin
            if (st_q.stage_addr) begin
                st_d.rf = rf_word_t'(st_q.stage_word);
            end else begin
                st_d.refw      = ref_word_t'(st_q.stage_word[REF_USED_W-1:0]);
                st_d.ref_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o      = st_q.strb_prev;
    assign rf_o        = st_q.rf;
    assign ref_o       = st_q.refw;
    assign ref_valid_o = st_q.ref_valid;

endmodule

// File: rtl/pgm_field_decode.sv
module pgm_field_decode
    import pgm_if_pkg::*;
(
    input  rf_word_t           rf_i,
    input  ref_word_t          ref_i,
    output logic [A_W-1:0]     a_cnt_o,
    output logic [M_W-1:0]     m_cnt_o,
    output logic [GAIN_W-1:0]  gain_o,
    output logic [HALF_W-1:0]  gain_half_o,
    output logic [REFC_W-1:0]  ref_cnt_o,
    output logic [PDS_W-1:0]   pd_state_o,
    output logic               pd_enable_o,
    output logic               pd_mon_en_o,
    output logic               pd_handoff_o,
    output logic               pd_swap_o
);

    pd_state_e pds;

    always_comb begin
        a_cnt_o   = rf_i.a;
        m_cnt_o   = rf_i.m;
        gain_o    = rf_i.gain;
        ref_cnt_o = ref_i.refc;
        pd_swap_o = ref_i.sense;
        pds       = pd_state_e'(ref_i.pds);
        pd_state_o = ref_i.pds;

        case (rf_i.gain)
            2'b00:   gain_half_o = 4'd2;
            2'b01:   gain_half_o = 4'd3;
            2'b10:   gain_half_o = 4'd5;
            default: gain_half_o = 4'd8;
        endcase

        pd_enable_o  = 1'b0;
        pd_mon_en_o  = 1'b1;
        pd_handoff_o = 1'b0;
        case (pds)
            PDS_RUN_QUIET: begin pd_enable_o = 1'b1; pd_mon_en_o = 1'b0; end
            PDS_RUN_MON:   pd_enable_o  = 1'b1;
            PDS_HANDOFF:   pd_handoff_o = 1'b1;
            default:       pd_enable_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/pgm_strobe_if.sv
module pgm_strobe_if
    import pgm_if_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_i,
    input  logic              addr_i,
    input  logic [15:0]       bus_i,
    output logic              cnt_rst_o,
    output logic              cp_disable_o,
    output logic [2:0]        a_cnt_o,
    output logic [10:0]       m_cnt_o,
    output logic [1:0]        cp_gain_o,
    output logic [3:0]        cp_gain_half_o,
    output logic [9:0]        ref_cnt_o,
    output logic [1:0]        pd_state_o,
    output logic              pd_enable_o,
    output logic              pd_mon_en_o,
    output logic              pd_lock_handoff_o,
    output logic              pd_swap_o,
    output logic              ref_valid_o
);

    localparam int SYNC_W = WORD_W + 2;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic              strb_s, addr_s;
    logic [WORD_W-1:0] bus_s;
    logic              hold;
    rf_word_t          rf_w;
    ref_word_t         ref_w;

    assign sync_in = {strb_i, addr_i, bus_i};

    pgm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_in),
        .sync_o  (sync_out)
    );

    assign {strb_s, addr_s, bus_s} = sync_out;

    pgm_load_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb_s      (strb_s),
        .addr_s      (addr_s),
        .bus_s       (bus_s),
        .hold_o      (hold),
        .rf_o        (rf_w),
        .ref_o       (ref_w),
        .ref_valid_o (ref_valid_o)
    );

    pgm_field_decode u_dec (
        .rf_i         (rf_w),
        .ref_i        (ref_w),
        .a_cnt_o      (a_cnt_o),
        .m_cnt_o      (m_cnt_o),
        .gain_o       (cp_gain_o),
        .gain_half_o  (cp_gain_half_o),
        .ref_cnt_o    (ref_cnt_o),
        .pd_state_o   (pd_state_o),
        .pd_enable_o  (pd_enable_o),
        .pd_mon_en_o  (pd_mon_en_o),
        .pd_handoff_o (pd_lock_handoff_o),
        .pd_swap_o    (pd_swap_o)
    );

    assign cnt_rst_o    = hold;
    assign cp_disable_o = hold;

endmodule

// File: rtl/pgm_strobe_if_chk.sv
module pgm_strobe_if_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cnt_rst_o,
    input logic [2:0]  a_cnt_o,
    input logic [10:0] m_cnt_o,
    input logic [1:0]  cp_gain_o,
    input logic [3:0]  cp_gain_half_o,
    input logic [9:0]  ref_cnt_o,
    input logic [1:0]  pd_state_o,
    input logic        pd_enable_o,
    input logic        pd_lock_handoff_o,
    input logic        pd_swap_o,
    input logic        ref_valid_o
);

    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rst_o && !$past(cnt_rst_o)) |->
        ($stable(a_cnt_o) && $stable(m_cnt_o) && $stable(cp_gain_o) &&
         $stable(ref_cnt_o) && $stable(pd_state_o) && $stable(pd_swap_o)));

    a_r11_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ref_valid_o));

    a_r11_valid_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_valid_o) |-> $fell(cnt_rst_o));

    a_r4_ref_changes_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_cnt_o) |-> $fell(cnt_rst_o));

    a_r4_rf_changes_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(m_cnt_o) |-> $fell(cnt_rst_o));

    a_r8_gain_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cp_gain_half_o) <= 2 && cp_gain_half_o >= 4'd2);

    a_r9_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_enable_o, pd_lock_handoff_o}));

endmodule

bind pgm_strobe_if pgm_strobe_if_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cnt_rst_o         (cnt_rst_o),
    .a_cnt_o           (a_cnt_o),
    .m_cnt_o           (m_cnt_o),
    .cp_gain_o         (cp_gain_o),
    .cp_gain_half_o    (cp_gain_half_o),
    .ref_cnt_o         (ref_cnt_o),
    .pd_state_o        (pd_state_o),
    .pd_enable_o       (pd_enable_o),
    .pd_lock_handoff_o (pd_lock_handoff_o),
    .pd_swap_o         (pd_swap_o),
    .ref_valid_o       (ref_valid_o)
);

// File: tb/pgm_strobe_if_test.sv
module pgm_strobe_if_test;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int LAT        = SYNC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strb_i = 1'b0;
    logic        addr_i = 1'b0;
    logic [15:0] bus_i = '0;
    logic        cnt_rst_o, cp_disable_o;
    logic [2:0]  a_cnt_o;
    logic [10:0] m_cnt_o;
    logic [1:0]  cp_gain_o;
    logic [3:0]  cp_gain_half_o;
    logic [9:0]  ref_cnt_o;
    logic [1:0]  pd_state_o;
    logic        pd_enable_o, pd_mon_en_o, pd_lock_handoff_o, pd_swap_o, ref_valid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] rf_m  = '0;
    logic [15:0] ref_m = '0;
    logic        refv_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgm_strobe_if #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .strb_i(strb_i), .addr_i(addr_i), .bus_i(bus_i),
        .cnt_rst_o(cnt_rst_o), .cp_disable_o(cp_disable_o),
        .a_cnt_o(a_cnt_o), .m_cnt_o(m_cnt_o), .cp_gain_o(cp_gain_o),
        .cp_gain_half_o(cp_gain_half_o), .ref_cnt_o(ref_cnt_o),
        .pd_state_o(pd_state_o), .pd_enable_o(pd_enable_o), .pd_mon_en_o(pd_mon_en_o),
        .pd_lock_handoff_o(pd_lock_handoff_o), .pd_swap_o(pd_swap_o),
        .ref_valid_o(ref_valid_o)
    );

    function automatic logic [3:0] exp_half(input logic [1:0] c);
        case (c)
            2'b00: return 4'd2;
            2'b01: return 4'd3;
            2'b10: return 4'd5;
            default: return 4'd8;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input logic hold_exp);
        chk("R4 cnt_rst", {31'b0, cnt_rst_o}, {31'b0, hold_exp});
        chk("R4 cp_disable", {31'b0, cp_disable_o}, {31'b0, hold_exp});
        chk("R7 a_cnt", {29'b0, a_cnt_o}, {29'b0, rf_m[2:0]});
        chk("R7 m_cnt", {21'b0, m_cnt_o}, {21'b0, rf_m[13:3]});
        chk("R7 gain", {30'b0, cp_gain_o}, {30'b0, rf_m[15:14]});
        chk("R8 gain_half", {28'b0, cp_gain_half_o}, {28'b0, exp_half(rf_m[15:14])});
        chk("R6 ref_cnt", {22'b0, ref_cnt_o}, {22'b0, ref_m[9:0]});
        chk("R6 pd_state", {30'b0, pd_state_o}, {30'b0, ref_m[11:10]});
        chk("R9 pd_enable", {31'b0, pd_enable_o}, {31'b0, !ref_m[11]});
        chk("R9 pd_mon", {31'b0, pd_mon_en_o}, {31'b0, ref_m[11:10] != 2'b00});
        chk("R9 handoff", {31'b0, pd_lock_handoff_o}, {31'b0, ref_m[11:10] == 2'b10});
        chk("R10 swap", {31'b0, pd_swap_o}, {31'b0, ref_m[12]});
        chk("R11 ref_valid", {31'b0, ref_valid_o}, {31'b0, refv_m});
    endtask

    task automatic commit(input logic a, input logic [15:0] w);
        if (a) rf_m = w;
        else begin ref_m = w; refv_m = 1'b1; end
    endtask

    // simple load with edge-timing probes; returns after outputs settle
    task automatic load(input logic a, input logic [15:0] w, input int hold);
        @(negedge clk);
        strb_i = 1'b1; addr_i = a; bus_i = w;
        repeat (LAT - 1) @(negedge clk);
        if (hold >= LAT - 1) check_all(1'b0);          // R4: one cycle early, still low
        repeat (hold - (LAT - 1) > 0 ? hold - (LAT - 1) : 0) @(negedge clk);
        strb_i = 1'b0;
        bus_i = ~w;                                     // R5: same-cycle change not kept
        addr_i = ~a;
        repeat (LAT - 1) @(negedge clk);
        if (hold >= LAT) check_all(1'b1);               // R4: still held, old value
        @(negedge clk);
        commit(a, w);
        check_all(1'b0);                                // R4/R2: released with new value
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check_all(1'b0);                                // R1 during reset
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all(1'b0);                                // R1 after reset

        // R2, R6, R10, R11: reference load, spare bits set
        load(1'b0, 16'hF6A5, 4);
        // R2, R7, R8, R12: divider load leaves reference alone
        load(1'b1, 16'h7ABC, 4);
        load(1'b1, 16'hC001, 1);
        load(1'b1, 16'h8002, 5);
        // R9: each detector state
        for (int s = 0; s < 4; s++) load(1'b0, {3'b000, s[0], s[1:0], 10'h155}, 3);

        // R5: tracking while strobe is high, address switches too
        @(negedge clk);
        strb_i = 1'b1; addr_i = 1'b0; bus_i = 16'h1234;
        repeat (2) @(negedge clk);
        addr_i = 1'b1; bus_i = 16'h4321;
        repeat (2) @(negedge clk);
        bus_i = 16'h5A5A;
        @(negedge clk);
        strb_i = 1'b0; bus_i = 16'hFFFF;
        repeat (LAT) @(negedge clk);
        commit(1'b1, 16'h5A5A);
        check_all(1'b0);

        // R3: bus noise with strobe low
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bus_i = 16'($urandom); addr_i = 1'($urandom);
        end
        repeat (LAT) @(negedge clk);
        check_all(1'b0);

        // random loads mixed with idle noise
        for (int i = 0; i < 300; i++) begin
            load(1'($urandom), 16'($urandom), 1 + int'($urandom_range(0, 4)));
            repeat ($urandom_range(0, 3)) begin
                @(negedge clk);
                bus_i = 16'($urandom); addr_i = 1'($urandom);
            end
            repeat (LAT) @(negedge clk);
            check_all(1'b0);                            // R3 after idle noise
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule